// File: doc/BRIEF.md
# Quad-channel UART FIFO bus interface

This block sits between a memory-mapped host bus and four UART channels. It holds a 64-byte transmit queue and a 64-byte receive queue for each channel. The host reaches each channel through two windows. In the byte window a write queues one transmit byte and a read takes one received byte. In the bulk window a single 32-bit write queues four transmit bytes at once. The bus is a plain address/data/strobe interface. Read data is combinational during the read cycle, and the queues update at the rising clock edge that ends the access.

Toward the serial side, each channel offers its transmit queue as a valid/ready source. Its receive queue accepts bytes through a valid/ready sink. Fill levels and a sticky overflow flag are visible for every channel.

Top module: `uart4_fifo_bus`

## Requirements
- R1: After reset every transmit and receive level is 0, every tx_valid is low, every rx_ready is high and every overflow flag is low.
- R2: A write with address bits 7:0 zero and bit 8 zero pushes bus_wdata[7:0] into the transmit queue of the channel named by address bits 10:9 (byte windows at 0x000, 0x200, 0x400, 0x600); the level rises by one.
- R3: A read with address bits 7:0 zero and bit 8 zero returns the oldest received byte of the selected channel on bus_rdata[7:0], with bits 31:8 zero, in the same cycle, and removes it at the clock edge.
- R4: A write with address bits 7:0 zero and bit 8 one (bulk windows at 0x100, 0x300, 0x500, 0x700) pushes four bytes in the order bits 7:0, 15:8, 23:16, 31:24; the level rises by four.
- R5: A bulk write to a channel with fewer than four free transmit entries stores nothing and sets that channel's overflow flag.
- R6: A byte write to a full transmit queue is discarded and sets the overflow flag; overflow flags stay set until reset and are per channel.
- R7: A byte-window read of an empty receive queue returns 0x00000000 and leaves the level at 0.
- R8: An access whose address bits 7:0 are not all zero reads as zero and changes nothing; a read of a bulk window reads zero and pops nothing.
- R9: tx_valid of a channel is high whenever its transmit queue is not empty, tx_data shows the oldest byte, and one byte leaves on each cycle with tx_valid and tx_ready both high.
- R10: rx_ready of a channel is high exactly when its receive queue is not full; a byte offered with rx_valid is stored only when rx_ready is high.
- R11: Levels are 7 bits wide and span 0 to 64; a push and a pop in the same cycle leave the level unchanged.
- R12: Each queue delivers bytes in arrival order, including across pointer wrap-around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 11 | Byte address: 10:9 channel, 8 bulk select, 7:0 must be zero |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe, one access per cycle |
| bus_rdata | output | 32 | Read data, valid while bus_rd is high |
| tx_valid | output | 4 | Per channel: transmit byte available |
| tx_data | output | 32 | Per channel oldest transmit byte, channel c in bits 8c+7:8c |
| tx_ready | input | 4 | Per channel: serializer takes the byte |
| rx_valid | input | 4 | Per channel: deserializer offers a byte |
| rx_data | input | 32 | Per channel received byte, channel c in bits 8c+7:8c |
| rx_ready | output | 4 | Per channel: receive queue can accept |
| tx_level | output | 28 | Per channel transmit fill, channel c in bits 7c+6:7c |
| rx_level | output | 28 | Per channel receive fill, channel c in bits 7c+6:7c |
| ovf | output | 4 | Per channel sticky transmit overflow flag |

## Verification
The bench fills one transmit queue to within three entries using bulk words. It then tries another bulk word. A design that admits a partial word, or that checks only for one free slot, raises the level above 61 or leaves the overflow flag clear. Byte writes to a full queue, reads of an empty queue and reads of a bulk window are probed next. A design that wraps its count, returns stale data or pops on a bulk read shows a wrong level or a wrong byte later. Draining a full queue in order catches lane swaps and pointer wrap errors. Misdecoded offsets show up as levels that move on writes that should be ignored.

// File: rtl/uart4_fifo_bus.sv
module uart4_fifo_bus #(
  parameter int NCH   = 4,
  parameter int DEPTH = 64,
  localparam int CW     = $clog2(NCH),
  localparam int CH_LSB = 9,
  localparam int AW     = CH_LSB + CW,
  localparam int PW     = $clog2(DEPTH),
  localparam int LW     = PW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [31:0]       bus_rdata,
  output logic [NCH-1:0]    tx_valid,
  output logic [NCH*8-1:0]  tx_data,
  input  logic [NCH-1:0]    tx_ready,
  input  logic [NCH-1:0]    rx_valid,
  input  logic [NCH*8-1:0]  rx_data,
  output logic [NCH-1:0]    rx_ready,
  output logic [NCH*LW-1:0] tx_level,
  output logic [NCH*LW-1:0] rx_level,
  output logic [NCH-1:0]    ovf
);

  wire          off_ok  = bus_addr[CH_LSB-2:0] == '0;
  wire          is_bulk = bus_addr[CH_LSB-1];
  wire [CW-1:0] sel     = bus_addr[AW-1:CH_LSB];

  logic [7:0]   rx_head [NCH];
  logic [NCH-1:0] rx_nz;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    wire hit     = off_ok && (sel == CW'(c));
    wire byte_wr = bus_wr && hit && !is_bulk;
    wire bulk_wr = bus_wr && hit && is_bulk;
    wire byte_rd = bus_rd && hit && !is_bulk;

    logic [7:0]    tmem [DEPTH];
    logic [PW-1:0] twp, trp;
    logic [LW-1:0] tcnt;
    wire  [LW-1:0] tfree  = LW'(DEPTH) - tcnt;
    wire           t_full = tcnt == LW'(DEPTH);
    wire           bulk_ok = tfree >= LW'(4);
    wire  [2:0]    tpush_n = (byte_wr && !t_full) ? 3'd1 :
                             (bulk_wr && bulk_ok) ? 3'd4 : 3'd0;
    wire           tpop = (tcnt != '0) && tx_ready[c];

    always_ff @(posedge clk)
      for (int k = 0; k < 4; k++)
        if (k < int'(tpush_n)) tmem[twp + PW'(k)] <= bus_wdata[8*k +: 8];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        twp <= '0; trp <= '0; tcnt <= '0; ovf[c] <= 1'b0;
      end else begin
        twp  <= twp + PW'(tpush_n);
        trp  <= trp + PW'(tpop);
        tcnt <= tcnt + LW'(tpush_n) - LW'(tpop);
        if ((byte_wr && t_full) || (bulk_wr && !bulk_ok)) ovf[c] <= 1'b1;
      end
    end

    logic [7:0]    rmem [DEPTH];
    logic [PW-1:0] rwp, rrp;
    logic [LW-1:0] rcnt;
    wire           r_full = rcnt == LW'(DEPTH);
    wire           rpush  = rx_valid[c] && !r_full;
    wire           rpop   = byte_rd && (rcnt != '0);

    always_ff @(posedge clk)
      if (rpush) rmem[rwp] <= rx_data[8*c +: 8];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rwp <= '0; rrp <= '0; rcnt <= '0;
      end else begin
        rwp  <= rwp + PW'(rpush);
        rrp  <= rrp + PW'(rpop);
        rcnt <= rcnt + LW'(rpush) - LW'(rpop);
      end
    end

    assign tx_valid[c]           = tcnt != '0;
    assign tx_data[8*c +: 8]     = tmem[trp];
    assign rx_ready[c]           = !r_full;
    assign tx_level[LW*c +: LW]  = tcnt;
    assign rx_level[LW*c +: LW]  = rcnt;
    assign rx_head[c]            = rmem[rrp];
    assign rx_nz[c]              = rcnt != '0;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd && off_ok && !is_bulk && rx_nz[sel]) bus_rdata[7:0] = rx_head[sel];
  end

endmodule

// File: rtl/uart4_fifo_bus_chk.sv
module uart4_fifo_bus_chk #(
  parameter int NCH = 4,
  parameter int DEPTH = 64,
  localparam int CW = $clog2(NCH),
  localparam int CH_LSB = 9,
  localparam int AW = CH_LSB + CW,
  localparam int LW = $clog2(DEPTH) + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [AW-1:0]     bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [31:0]       bus_rdata,
  input logic [NCH-1:0]    tx_valid,
  input logic [NCH-1:0]    tx_ready,
  input logic [NCH*LW-1:0] tx_level,
  input logic [NCH*LW-1:0] rx_level,
  input logic [NCH-1:0]    ovf
);

  wire base_ok = bus_addr[CH_LSB-2:0] == '0;

  // R8
  bad_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !base_ok) |-> bus_rdata == '0);

  for (genvar c = 0; c < NCH; c++) begin : g_c
    wire [LW-1:0] tl  = tx_level[LW*c +: LW];
    wire [LW-1:0] rl  = rx_level[LW*c +: LW];
    wire          pop = tx_valid[c] && tx_ready[c];
    wire          me  = base_ok && bus_addr[AW-1:CH_LSB] == CW'(c);

    // R11
    level_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tl <= LW'(DEPTH) && rl <= LW'(DEPTH));

    // R5
    bulk_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && me && bus_addr[CH_LSB-1] && tl > LW'(DEPTH - 4))
      |=> (tl == $past(tl) - LW'($past(pop))) && ovf[c]);

    // R6
    full_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && me && !bus_addr[CH_LSB-1] && tl == LW'(DEPTH)) |=> ovf[c]);

    // R6
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf[c] |=> ovf[c]);

    // R7
    empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && me && !bus_addr[CH_LSB-1] && rl == '0) |-> bus_rdata == '0);
  end

endmodule

bind uart4_fifo_bus uart4_fifo_bus_chk #(.NCH(NCH), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_rd(bus_rd), .bus_rdata(bus_rdata), .tx_valid(tx_valid),
  .tx_ready(tx_ready), .tx_level(tx_level), .rx_level(rx_level), .ovf(ovf)
);

// File: tb/sim_uart4_fifo_bus.sv
module sim_uart4_fifo_bus;
  logic        clk = 0, rst_n = 0;
  logic [10:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        bus_wr = 0, bus_rd = 0;
  logic [3:0]  tx_valid, tx_ready = '0, rx_valid = '0, rx_ready, ovf;
  logic [31:0] tx_data, rx_data = '0;
  logic [27:0] tx_level, rx_level;

  int checks = 0, errors = 0;

  uart4_fifo_bus u0 (.*);

  always #5 clk = ~clk;

  localparam logic [50:0] VEC [8] = '{
    {11'h000, 32'h000000A1, 7'd1, 1'b0},
    {11'h100, 32'h44332211, 7'd5, 1'b0},
    {11'h300, 32'hDDCCBBAA, 7'd4, 1'b0},
    {11'h200, 32'h00000055, 7'd5, 1'b0},
    {11'h600, 32'h00000077, 7'd1, 1'b0},
    {11'h500, 32'h0C0B0A09, 7'd4, 1'b0},
    {11'h401, 32'h000000EE, 7'd4, 1'b0},
    {11'h180, 32'h12345678, 7'd5, 1'b0}
  };

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic bus_write(logic [10:0] a, logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic bus_read(logic [10:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic rx_push(int ch, logic [7:0] d);
    @(negedge clk); rx_valid[ch] = 1; rx_data[8*ch +: 8] = d;
    @(negedge clk); rx_valid[ch] = 0;
  endtask

  task automatic tx_pop(int ch, output logic [7:0] d);
    @(negedge clk); d = tx_data[8*ch +: 8]; tx_ready[ch] = 1;
    @(negedge clk); tx_ready[ch] = 0;
  endtask

  function automatic logic [6:0] tl(int ch); return tx_level[7*ch +: 7]; endfunction
  function automatic logic [6:0] rl(int ch); return rx_level[7*ch +: 7]; endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0]  b;
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 tx_level", 32'(tx_level), 0);
    check("R1 rx_level", 32'(rx_level), 0);
    check("R1 tx_valid", 32'(tx_valid), 0);
    check("R1 rx_ready", 32'(rx_ready), 32'hF);
    check("R1 ovf", 32'(ovf), 0);

    for (int i = 0; i < 8; i++) begin
      bus_write(VEC[i][50:40], VEC[i][39:8]);
      check("R2/R4/R8 level after write", 32'(tl(int'(VEC[i][50:49]))), 32'(VEC[i][7:1]));
      check("R5/R6 ovf after write", 32'(ovf[VEC[i][50:49]]), 32'(VEC[i][0]));
    end

    check("R9 tx_valid ch0", 32'(tx_valid[0]), 1);
    foreach (VEC[i]) ;
    begin
      logic [7:0] e0 [5] = '{8'hA1, 8'h11, 8'h22, 8'h33, 8'h44};
      logic [7:0] e1 [5] = '{8'hAA, 8'hBB, 8'hCC, 8'hDD, 8'h55};
      for (int i = 0; i < 5; i++) begin tx_pop(0, b); check("R4/R9 ch0 order", 32'(b), 32'(e0[i])); end
      for (int i = 0; i < 5; i++) begin tx_pop(1, b); check("R4/R9 ch1 order", 32'(b), 32'(e1[i])); end
    end
    check("R9 ch0 empty", 32'(tx_valid[0]), 0);
    check("R9 ch1 level", 32'(tl(1)), 0);
    check("R8 ch2 untouched by bad offset", 32'(tl(2)), 4);

    for (int j = 0; j < 15; j++)
      bus_write(11'h700, {8'(4*j+4), 8'(4*j+3), 8'(4*j+2), 8'(4*j+1)});
    check("R4 ch3 level 61", 32'(tl(3)), 61);
    check("R5 no ovf yet", 32'(ovf[3]), 0);
    bus_write(11'h700, 32'hDEADBEEF);
    check("R5 bulk dropped level", 32'(tl(3)), 61);
    check("R5 bulk drop sets ovf", 32'(ovf[3]), 1);
    check("R6 ovf per channel", 32'(ovf[2:0]), 0);
    for (int i = 0; i < 3; i++) bus_write(11'h600, 32'(8'hF0 + i));
    check("R11 level 64", 32'(tl(3)), 64);
    bus_write(11'h600, 32'h99);
    check("R6 full byte dropped", 32'(tl(3)), 64);
    check("R6 ovf sticky", 32'(ovf[3]), 1);
    tx_pop(3, b); check("R12 first", 32'(b), 32'h77);
    for (int i = 1; i <= 60; i++) begin tx_pop(3, b); check("R12 bulk order", 32'(b), i); end
    for (int i = 0; i < 3; i++) begin tx_pop(3, b); check("R12 tail order", 32'(b), 32'(8'hF0 + i)); end
    check("R12 drained", 32'(tl(3)), 0);

    rx_push(1, 8'h31); rx_push(1, 8'h32); rx_push(1, 8'h33);
    check("R10 rx level", 32'(rl(1)), 3);
    bus_read(11'h300, r); check("R8 bulk read zero", r, 0);
    check("R8 bulk read no pop", 32'(rl(1)), 3);
    bus_read(11'h201, r); check("R8 bad offset read", r, 0);
    bus_read(11'h200, r); check("R3 read 1", r, 32'h31);
    bus_read(11'h200, r); check("R3 read 2", r, 32'h32);
    bus_read(11'h200, r); check("R3 read 3", r, 32'h33);
    bus_read(11'h200, r); check("R7 empty read", r, 0);
    check("R7 level stays 0", 32'(rl(1)), 0);

    for (int i = 0; i < 64; i++) rx_push(2, 8'(i + 8'h40));
    check("R10 rx full level", 32'(rl(2)), 64);
    check("R10 rx_ready low", 32'(rx_ready[2]), 0);
    rx_push(2, 8'hEE);
    check("R10 push ignored", 32'(rl(2)), 64);
    bus_read(11'h400, r); check("R3/R12 rx oldest", r, 32'h40);
    check("R10 rx_ready back", 32'(rx_ready[2]), 1);

    bus_write(11'h000, 32'h61);
    @(negedge clk); tx_ready[0] = 1; bus_addr = 11'h000; bus_wdata = 32'h62; bus_wr = 1;
    @(negedge clk); tx_ready[0] = 0; bus_wr = 0;
    check("R11 push+pop level", 32'(tl(0)), 1);
    check("R11 push+pop data", 32'(tx_data[7:0]), 32'h62);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule